// File: doc/BRIEF.md
# Windowed Threshold Interrupt with Persistence

This block watches the stream of channel-0 conversion results from a light sensor front end. Each result arrives with a one-cycle end-of-cycle strobe. The block compares the result against a programmable 16-bit window bounded by a low and a high threshold, and counts how many results in a row have landed outside that window. It raises an interrupt once the persistence rule is met.

The interrupt is level-style and active low. It is held by a pending flag that only a clear strobe or disabling the output removes. The persistence selector works as follows:

- A selector of zero asks for an interrupt on every conversion, whatever the value.
- A selector of one fires on the first result outside the window.
- Any larger selector N fires only after N consecutive results outside the window.

The second input channel of the sensor is never seen by this block.

Top module: `lwi_window_irq`

## Requirements
- R1: A result is outside the window when it is less than or equal to `lo_thresh`, or strictly greater than `hi_thresh`. A result equal to `hi_thresh`, or one above `lo_thresh` and not above `hi_thresh`, is inside.
- R2: With `persist_sel` = 0, every `cycle_done` strobe sets the pending flag, even for a result inside the window.
- R3: With `persist_sel` = 1, a single strobe carrying an outside result sets the pending flag.
- R4: With `persist_sel` = N (2..15), the pending flag is set on the Nth consecutive outside result and not before.
- R5: A strobe carrying an inside result restarts the run of consecutive outside results from zero.
- R6: The run counter saturates at 15 instead of wrapping. With `persist_sel` = 15, every outside result after a run of 15 sets the flag again.
- R7: `irq_n` is the inverse of `irq_pending`. Once set, the flag holds through any number of cycles until it is cleared.
- R8: A one-cycle `irq_clear` pulse drops the pending flag on the next clock edge, so `irq_n` returns high.
- R9: When a set condition and `irq_clear` fall on the same clock edge, the set wins and the flag stays high.
- R10: The output is enabled only when `irq_mode` = 2'b01. Any other mode holds the flag low and `irq_n` high, records no event, and drops a flag that was already pending.
- R11: Results presented while `cycle_done` is low are ignored. They neither advance the run nor set the flag.
- R12: Flag and counter reset to zero on the active-low `rst_n`, which leaves `irq_n` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cycle_done | input | 1 | One-cycle strobe marking a new conversion result |
| ch0_value | input | 16 | Channel-0 conversion result |
| lo_thresh | input | 16 | Low window bound (inclusive trigger) |
| hi_thresh | input | 16 | High window bound (exclusive trigger) |
| irq_mode | input | 2 | 2'b01 enables the output; other codes disable it |
| persist_sel | input | 4 | Persistence selector 0..15 |
| irq_clear | input | 1 | One-cycle clear pulse from a command write |
| irq_n | output | 1 | Interrupt pin, active low, level |
| irq_pending | output | 1 | Pending flag, active high |

## Verification
The set path and the clear path can land on the same clock edge. That happens when a clear command arrives in the very cycle a conversion ends and meets the persistence rule. The bench provokes this by driving `cycle_done` and `irq_clear` together under persistence zero, and under persistence one with an outside result. It judges the result by requiring `irq_pending` to be high and `irq_n` low one cycle later. A lone clear pulse is then required to drop the flag, which shows that the flag held because the set won and not because the clear was lost.

// File: rtl/lwi_pkg.sv
`timescale 1ns/1ps
package lwi_pkg;

  // Mode code that enables the interrupt output; every other code disables it.
  localparam logic [1:0] MODE_LEVEL = 2'b01;

  // Persistence selector value meaning "fire on every conversion".
  localparam int unsigned PERSIST_ALWAYS = 0;

  // Events raised per conversion, grouped for readability at the top level.
  typedef struct packed {
    logic outside;   // result left the window
    logic met;       // persistence rule satisfied this strobe
    logic fire;      // qualified set of the pending flag
  } lwi_evt_t;

endpackage

// File: rtl/lwi_window_cmp.sv
`timescale 1ns/1ps
module lwi_window_cmp #(
  parameter int unsigned DATA_W = 16
) (
  input  logic [DATA_W-1:0] sample,
  input  logic [DATA_W-1:0] lo_bound,
  input  logic [DATA_W-1:0] hi_bound,
  output logic              outside
);

  // Low bound triggers inclusively, high bound exclusively.
  function automatic logic is_outside(
    input logic [DATA_W-1:0] v,
    input logic [DATA_W-1:0] lo,
    input logic [DATA_W-1:0] hi
  );
    logic below;
    logic above;
    below = (v <= lo);
    above = (v > hi);
    return below | above;
  endfunction

  always_comb begin
    outside = is_outside(sample, lo_bound, hi_bound);
  end

endmodule

// File: rtl/lwi_persist_track.sv
`timescale 1ns/1ps
module lwi_persist_track #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe,
  input  logic             outside,
  input  logic [CNT_W-1:0] persist_sel,
  output logic [CNT_W-1:0] run_count,
  output logic             met
);

  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] CNT_ZERO = '0;

  // Saturating increment: holds at the top code rather than wrapping.
  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] c);
    if (c == CNT_MAX) begin
      return CNT_MAX;
    end
    return c + 1'b1;
  endfunction

  // Persistence rule evaluated against the run length including this result.
  function automatic logic rule_met(
    input logic [CNT_W-1:0] sel,
    input logic             outs,
    input logic [CNT_W-1:0] run_after
  );
    if (sel == CNT_ZERO) begin
      return 1'b1;
    end
    return outs && (run_after >= sel);
  endfunction

  logic [CNT_W-1:0] run_next;

  always_comb begin
    run_next = outside ? sat_inc(run_count) : CNT_ZERO;
    met      = strobe && rule_met(persist_sel, outside, run_next);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_count <= CNT_ZERO;
    end else if (strobe) begin
      run_count <= run_next;
    end
  end

endmodule

// File: rtl/lwi_pend_latch.sv
`timescale 1ns/1ps
module lwi_pend_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic set_req,
  input  logic clr_req,
  output logic pending
);

  // Priority: disabled output drops everything, then set beats clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= 1'b0;
    end else if (!enable) begin
      pending <= 1'b0;
    end else if (set_req) begin
      pending <= 1'b1;
    end else if (clr_req) begin
      pending <= 1'b0;
    end
  end

endmodule

// File: rtl/lwi_window_irq.sv
`timescale 1ns/1ps
module lwi_window_irq #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cycle_done,
  input  logic [DATA_W-1:0] ch0_value,
  input  logic [DATA_W-1:0] lo_thresh,
  input  logic [DATA_W-1:0] hi_thresh,
  input  logic [1:0]        irq_mode,
  input  logic [CNT_W-1:0]  persist_sel,
  input  logic              irq_clear,
  output logic              irq_n,
  output logic              irq_pending
);

  import lwi_pkg::*;

  // Named internal events, exposed for the bound checker.
  lwi_evt_t         evt;
  logic             outside_evt;
  logic             met_evt;
  logic             fire_evt;
  logic             out_enable;
  logic [CNT_W-1:0] run_count;

  assign out_enable = (irq_mode == MODE_LEVEL);

  lwi_window_cmp #(.DATA_W(DATA_W)) u_cmp (
    .sample   (ch0_value),
    .lo_bound (lo_thresh),
    .hi_bound (hi_thresh),
    .outside  (outside_evt)
  );

  lwi_persist_track #(.CNT_W(CNT_W)) u_track (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobe      (cycle_done),
    .outside     (outside_evt),
    .persist_sel (persist_sel),
    .run_count   (run_count),
    .met         (met_evt)
  );

  always_comb begin
    evt.outside = outside_evt;
    evt.met     = met_evt;
    evt.fire    = met_evt && out_enable;
  end

  assign fire_evt = evt.fire;

  lwi_pend_latch u_pend (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (out_enable),
    .set_req (fire_evt),
    .clr_req (irq_clear),
    .pending (irq_pending)
  );

  assign irq_n = ~irq_pending;

endmodule

// File: rtl/lwi_window_irq_chk.sv
`timescale 1ns/1ps
module lwi_window_irq_chk #(
  parameter int unsigned CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cycle_done,
  input logic [1:0]       irq_mode,
  input logic             irq_clear,
  input logic             irq_n,
  input logic             irq_pending,
  input logic             outside_evt,
  input logic             fire_evt,
  input logic [CNT_W-1:0] run_count
);

  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire_evt |=> irq_pending);

  // R8
  clear_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clear && !fire_evt) |=> !irq_pending);

  // R10
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_mode != 2'b01) |=> (!irq_pending && irq_n));

  // R5
  run_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cycle_done && !outside_evt) |=> (run_count == '0));

  // R6
  run_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cycle_done && outside_evt && run_count == CNT_TOP) |=> (run_count == CNT_TOP));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cycle_done && !irq_clear && irq_mode == 2'b01) |=> $stable(irq_pending));

  // R7
  rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_pending) |-> $past(fire_evt));

endmodule

bind lwi_window_irq lwi_window_irq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cycle_done  (cycle_done),
  .irq_mode    (irq_mode),
  .irq_clear   (irq_clear),
  .irq_n       (irq_n),
  .irq_pending (irq_pending),
  .outside_evt (outside_evt),
  .fire_evt    (fire_evt),
  .run_count   (run_count)
);

// File: tb/test_lwi_window_irq.sv
`timescale 1ns/1ps
module test_lwi_window_irq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cycle_done = 1'b0;
  logic [15:0] ch0_value = '0;
  logic [15:0] lo_thresh = 16'd100;
  logic [15:0] hi_thresh = 16'd200;
  logic [1:0]  irq_mode = 2'b01;
  logic [3:0]  persist_sel = 4'd1;
  logic        irq_clear = 1'b0;
  logic        irq_n;
  logic        irq_pending;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  lwi_window_irq i_lwi_window_irq (
    .clk(clk), .rst_n(rst_n), .cycle_done(cycle_done), .ch0_value(ch0_value),
    .lo_thresh(lo_thresh), .hi_thresh(hi_thresh), .irq_mode(irq_mode),
    .persist_sel(persist_sel), .irq_clear(irq_clear), .irq_n(irq_n),
    .irq_pending(irq_pending)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Pin and flag together: pin must mirror the flag (R7).
  task automatic check_irq(input string tag, input bit exp_pend);
    check(tag, {31'd0, irq_pending}, {31'd0, exp_pend});
    check({tag, " R7 pin"}, {31'd0, irq_n}, {31'd0, !exp_pend});
  endtask

  task automatic strobe(input logic [15:0] v);
    @(negedge clk);
    ch0_value  = v;
    cycle_done = 1'b1;
    @(negedge clk);
    cycle_done = 1'b0;
  endtask

  task automatic do_clear();
    @(negedge clk);
    irq_clear = 1'b1;
    @(negedge clk);
    irq_clear = 1'b0;
  endtask

  // Bring the run to zero and the flag low.
  task automatic restart(input logic [3:0] p);
    persist_sel = 4'd1;
    irq_mode    = 2'b01;
    strobe(16'd150);
    do_clear();
    persist_sel = p;
  endtask

  task automatic t_reset();
    check_irq("R12 reset", 1'b0);
  endtask

  task automatic t_bounds();
    restart(4'd1);
    strobe(16'd101);  check_irq("R1 just above low is inside", 1'b0);
    strobe(16'd200);  check_irq("R1 equal high is inside", 1'b0);
    strobe(16'd100);  check_irq("R1 equal low is outside", 1'b1);
    do_clear();
    strobe(16'd201);  check_irq("R3 single result above high fires", 1'b1);
    do_clear();
    strobe(16'd0);    check_irq("R1 zero is outside", 1'b1);
  endtask

  task automatic t_every();
    restart(4'd0);
    strobe(16'd150);  check_irq("R2 inside result fires with persist 0", 1'b1);
    do_clear();
    check_irq("R8 clear drops flag", 1'b0);
  endtask

  task automatic t_persist();
    restart(4'd3);
    strobe(16'd300);  check_irq("R4 run 1 of 3", 1'b0);
    strobe(16'd300);  check_irq("R4 run 2 of 3", 1'b0);
    strobe(16'd150);  check_irq("R5 inside breaks run", 1'b0);
    strobe(16'd50);   check_irq("R5 run restarted 1", 1'b0);
    strobe(16'd50);   check_irq("R5 run restarted 2", 1'b0);
    strobe(16'd50);   check_irq("R4 third consecutive fires", 1'b1);
  endtask

  task automatic t_saturate();
    restart(4'd15);
    for (int i = 0; i < 14; i++) strobe(16'd300);
    check_irq("R4 fourteen of fifteen", 1'b0);
    strobe(16'd300);
    check_irq("R4 fifteenth fires", 1'b1);
    for (int i = 0; i < 3; i++) begin
      do_clear();
      check_irq("R8 cleared in saturated run", 1'b0);
      strobe(16'd300);
      check_irq("R6 saturated run fires again", 1'b1);
    end
  endtask

  task automatic t_hold_idle();
    restart(4'd1);
    ch0_value = 16'd5;
    repeat (8) @(negedge clk);
    check_irq("R11 outside value without strobe ignored", 1'b0);
    strobe(16'd5);
    repeat (10) @(negedge clk);
    check_irq("R7 flag holds while idle", 1'b1);
  endtask

  task automatic t_collide();
    restart(4'd0);
    @(negedge clk);
    ch0_value = 16'd150; cycle_done = 1'b1; irq_clear = 1'b1;
    @(negedge clk);
    cycle_done = 1'b0; irq_clear = 1'b0;
    check_irq("R9 set beats clear persist 0", 1'b1);
    persist_sel = 4'd1;
    @(negedge clk);
    ch0_value = 16'd999; cycle_done = 1'b1; irq_clear = 1'b1;
    @(negedge clk);
    cycle_done = 1'b0; irq_clear = 1'b0;
    check_irq("R9 set beats clear persist 1", 1'b1);
    do_clear();
    check_irq("R9 lone clear then drops", 1'b0);
  endtask

  task automatic t_disable();
    restart(4'd0);
    irq_mode = 2'b00;
    strobe(16'd150);  check_irq("R10 mode 00 records nothing", 1'b0);
    irq_mode = 2'b10;
    strobe(16'd5);    check_irq("R10 mode 10 records nothing", 1'b0);
    irq_mode = 2'b11;
    strobe(16'd5);    check_irq("R10 mode 11 records nothing", 1'b0);
    irq_mode = 2'b01;
    repeat (2) @(negedge clk);
    check_irq("R10 no stale event on enable", 1'b0);
    strobe(16'd150);  check_irq("R10 enabled fires", 1'b1);
    @(negedge clk);
    irq_mode = 2'b00;
    @(negedge clk);
    check_irq("R10 disabling drops flag", 1'b0);
    irq_mode = 2'b01;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_bounds();
    t_every();
    t_persist();
    t_saturate();
    t_hold_idle();
    t_collide();
    t_disable();
    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired before completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule